// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block holds a microcontroller in reset while its supplies are unsafe and for a chosen time after they recover. It receives digital flags from analog comparators (rail undervoltage, battery undervoltage, battery early warning), a timeout request from a watchdog, a 1 MHz timing tick and a two-bit configuration code from a pin interrogator. It drives an active-low reset, an active-low warning, the threshold code that the rail comparator uses, and a one-clock pulse that marks the end of each reset so that a watchdog can open its first window.

Every comparator flag is resynchronised and then debounced over a number of ticks. This debounce also sets the reaction delay of the reset. After power-up, once the rail has come good, the block waits an evaluation window. It then captures the configuration code one time only, and counts the selected reset duration before it releases. Later recoveries and watchdog timeouts reuse the captured duration and skip the evaluation window. The warning output follows the battery-warning flag and does not depend on the reset.

Top module: `supv_rst_gen`

## Requirements
- R1: While the asynchronous reset is applied and just after it, res_n_o is 0, warn_n_o is 1, rst_done_o is 0 and thr_code_o is 2'b00.
- R2: When the filtered rail flag or the filtered battery undervoltage flag is 1, res_n_o goes to 0 on the following clock and stays 0 while either flag is 1.
- R3: A comparator flag takes effect only after its synchronised value has differed from the filtered value on FILT_TICKS consecutive ticks. A shorter excursion has no effect on the outputs.
- R4: At the first recovery after power-up, an evaluation window of EVAL_TICKS ticks passes first. The configuration is captured at the end of that window, and only then does the reset duration start.
- R5: The reset duration is DUR_SHORT_TICKS ticks when code bit 0 is 0 and DUR_LONG_TICKS ticks when it is 1. The release happens on a tick.
- R6: The configuration code is captured once. Later changes to cfg_code_i affect neither the duration nor thr_code_o.
- R7: A watchdog timeout pulse while res_n_o is 1 drives res_n_o to 0 on the next clock, for the captured duration.
- R8: warn_n_o is the inverse of the filtered battery-warning flag, whatever the state of res_n_o.
- R9: thr_code_o is 2'b10 when mode_3v3_i is 1, whatever the code bit 1. Otherwise it is {1'b0, captured code bit 1}.
- R10: rst_done_o is 1 for exactly one clock, in the first cycle in which res_n_o is 1 after each release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock enable at 1 MHz |
| rail_uv_i | input | 1 | Rail below its threshold (1 = low) |
| batt_uv_i | input | 1 | Battery below its reset level (1 = low) |
| batt_warn_i | input | 1 | Battery below its warning level (1 = low) |
| wd_timeout_i | input | 1 | One-clock watchdog timeout request |
| mode_3v3_i | input | 1 | 3.3 V output mode selected |
| cfg_code_i | input | 2 | Bit 0 long duration, bit 1 high threshold |
| res_n_o | output | 1 | Active-low reset to the microcontroller |
| warn_n_o | output | 1 | Active-low early battery warning |
| rst_done_o | output | 1 | One-clock pulse at each reset release |
| thr_code_o | output | 2 | Rail threshold: 00 low, 01 high, 10 fixed |

## Verification
The bench builds the block with FILT_TICKS=3, EVAL_TICKS=5, DUR_SHORT_TICKS=8 and DUR_LONG_TICKS=20, and it drives the tick itself. With these values, every debounce edge, the evaluation window and both durations can be counted to the exact tick, including the tick just before each boundary. The short values also let the bench cover a second power-up with a different code, a sub-threshold glitch, a battery dip and a watchdog restart in only a few thousand clocks.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_DELAY = 2'd2,
    ST_RUN   = 2'd3
  } supv_state_e;

  localparam int unsigned FLAG_RAIL = 0;
  localparam int unsigned FLAG_BATT = 1;
  localparam int unsigned FLAG_WARN = 2;
  localparam int unsigned NUM_FLAGS = 3;

  localparam logic [1:0] THR_LOW   = 2'b00;
  localparam logic [1:0] THR_HIGH  = 2'b01;
  localparam logic [1:0] THR_FIXED = 2'b10;
endpackage

// File: rtl/supv_flag_filter.sv
module supv_flag_filter #(
  parameter int unsigned FILT_TICKS  = 25,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          RST_VAL     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_i,
  output logic flt_o
);
  localparam int unsigned CW = $clog2(FILT_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   flt_q, flt_d;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {SYNC_STAGES{RST_VAL}};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  always_comb begin
    flt_d = flt_q;
    cnt_d = cnt_q;
    if (synced == flt_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == CW'(FILT_TICKS - 1)) begin
        flt_d = synced;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= RST_VAL;
      cnt_q <= '0;
    end else begin
      flt_q <= flt_d;
      cnt_q <= cnt_d;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/supv_cfg_latch.sv
module supv_cfg_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_i,
  input  logic [1:0] code_i,
  output logic       valid_o,
  output logic       dur_long_o,
  output logic       thr_high_o
);
  logic valid_q, valid_d;
  logic dur_q, dur_d;
  logic thr_q, thr_d;

  always_comb begin
    valid_d = valid_q;
    dur_d   = dur_q;
    thr_d   = thr_q;
    if (cap_i && !valid_q) begin
      valid_d = 1'b1;
      dur_d   = code_i[0];
      thr_d   = code_i[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dur_q   <= 1'b0;
      thr_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      dur_q   <= dur_d;
      thr_q   <= thr_d;
    end
  end

  assign valid_o    = valid_q;
  assign dur_long_o = dur_q;
  assign thr_high_o = thr_q;
endmodule

// File: rtl/supv_tick_timer.sv
module supv_tick_timer #(
  parameter int unsigned CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [CW-1:0] term_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign hit_o = tick_i && (cnt_q == term_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/supv_rst_gen.sv
module supv_rst_gen
  import supv_pkg::*;
#(
  parameter int unsigned FILT_TICKS      = 25,
  parameter int unsigned EVAL_TICKS      = 100,
  parameter int unsigned DUR_SHORT_TICKS = 10000,
  parameter int unsigned DUR_LONG_TICKS  = 65000,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       rail_uv_i,
  input  logic       batt_uv_i,
  input  logic       batt_warn_i,
  input  logic       wd_timeout_i,
  input  logic       mode_3v3_i,
  input  logic [1:0] cfg_code_i,
  output logic       res_n_o,
  output logic       warn_n_o,
  output logic       rst_done_o,
  output logic [1:0] thr_code_o
);
  localparam int unsigned MAX_DUR  = (DUR_LONG_TICKS > DUR_SHORT_TICKS) ? DUR_LONG_TICKS : DUR_SHORT_TICKS;
  localparam int unsigned MAX_TERM = (MAX_DUR > EVAL_TICKS) ? MAX_DUR : EVAL_TICKS;
  localparam int unsigned TCW      = $clog2(MAX_TERM + 1);
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = 3'b001;

  logic [NUM_FLAGS-1:0] flag_raw, flag_flt;
  supv_state_e          st_q, st_d;
  logic                 supply_bad;
  logic                 tmr_clr, tmr_hit;
  logic [TCW-1:0]       tmr_term;
  logic                 cfg_cap, cfg_valid, dur_long, thr_high;
  logic                 done_q, done_d;

  assign flag_raw[FLAG_RAIL] = rail_uv_i;
  assign flag_raw[FLAG_BATT] = batt_uv_i;
  assign flag_raw[FLAG_WARN] = batt_warn_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
    supv_flag_filter #(
      .FILT_TICKS (FILT_TICKS),
      .SYNC_STAGES(SYNC_STAGES),
      .RST_VAL    (FLAG_RST[g])
    ) flt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick_i(tick_i),
      .raw_i (flag_raw[g]),
      .flt_o (flag_flt[g])
    );
  end

  assign supply_bad = flag_flt[FLAG_RAIL] | flag_flt[FLAG_BATT];

  supv_cfg_latch cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (cfg_cap),
    .code_i    (cfg_code_i),
    .valid_o   (cfg_valid),
    .dur_long_o(dur_long),
    .thr_high_o(thr_high)
  );

  always_comb begin
    if (st_q == ST_EVAL)  tmr_term = TCW'(EVAL_TICKS - 1);
    else if (dur_long)    tmr_term = TCW'(DUR_LONG_TICKS - 1);
    else                  tmr_term = TCW'(DUR_SHORT_TICKS - 1);
  end

  supv_tick_timer #(.CW(TCW)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_i(tick_i),
    .clr_i (tmr_clr),
    .term_i(tmr_term),
    .hit_o (tmr_hit)
  );

  always_comb begin
    st_d    = st_q;
    tmr_clr = 1'b0;
    cfg_cap = 1'b0;
    done_d  = 1'b0;
    if (supply_bad) begin
      st_d    = ST_HOLD;
      tmr_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_HOLD: begin
          tmr_clr = 1'b1;
          st_d    = cfg_valid ? ST_DELAY : ST_EVAL;
        end
        ST_EVAL: begin
          if (tmr_hit) begin
            cfg_cap = 1'b1;
            tmr_clr = 1'b1;
            st_d    = ST_DELAY;
          end
        end
        ST_DELAY: begin
          if (tmr_hit) begin
            tmr_clr = 1'b1;
            done_d  = 1'b1;
            st_d    = ST_RUN;
          end
        end
        ST_RUN: begin
          tmr_clr = 1'b1;
          if (wd_timeout_i) st_d = ST_DELAY;
        end
        default: st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HOLD;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign res_n_o    = (st_q == ST_RUN);
  assign rst_done_o = done_q;
  assign warn_n_o   = ~flag_flt[FLAG_WARN];
  assign thr_code_o = mode_3v3_i ? THR_FIXED : (thr_high ? THR_HIGH : THR_LOW);
endmodule

// File: rtl/supv_rst_gen_chk.sv
module supv_rst_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic wd_timeout_i,
  input logic res_n_o,
  input logic warn_n_o,
  input logic rst_done_o,
  input logic supply_bad,
  input logic cfg_valid,
  input logic dur_long
);
  assert_bad_holds_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    supply_bad |=> !res_n_o);

  assert_warn_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(warn_n_o));

  assert_release_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_n_o) |-> $past(tick_i));

  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> ($stable(dur_long) && cfg_valid));

  assert_wd_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_n_o && wd_timeout_i) |=> !res_n_o);

  assert_done_marks_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done_o |-> (res_n_o && !$past(res_n_o)));

  assert_release_signalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_n_o) |-> rst_done_o);
endmodule

bind supv_rst_gen supv_rst_gen_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .wd_timeout_i(wd_timeout_i),
  .res_n_o     (res_n_o),
  .warn_n_o    (warn_n_o),
  .rst_done_o  (rst_done_o),
  .supply_bad  (supply_bad),
  .cfg_valid   (cfg_valid),
  .dur_long    (dur_long)
);

// File: tb/supv_rst_gen_tb.sv
`timescale 1ns/1ps
module supv_rst_gen_tb_top;
  localparam int FT = 3;
  localparam int ET = 5;
  localparam int DS = 8;
  localparam int DL = 20;

  logic       clk = 1'b0;
  logic       rst_n, tick, rail_uv, batt_uv, batt_warn, wd_to, mode_3v3;
  logic [1:0] cfg_code;
  logic       res_n, warn_n, rst_done;
  logic [1:0] thr_code;

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;

  always #2.5 clk = ~clk;

  supv_rst_gen #(
    .FILT_TICKS(FT), .EVAL_TICKS(ET), .DUR_SHORT_TICKS(DS), .DUR_LONG_TICKS(DL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rail_uv_i(rail_uv),
    .batt_uv_i(batt_uv), .batt_warn_i(batt_warn), .wd_timeout_i(wd_to),
    .mode_3v3_i(mode_3v3), .cfg_code_i(cfg_code), .res_n_o(res_n),
    .warn_n_o(warn_n), .rst_done_o(rst_done), .thr_code_o(thr_code)
  );

  always @(posedge clk) if (rst_n === 1'b1 && rst_done === 1'b1) done_cnt++;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic hard_reset(logic [1:0] code);
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; rail_uv = 1'b1; batt_uv = 1'b0;
    batt_warn = 1'b0; wd_to = 1'b0; mode_3v3 = 1'b0; cfg_code = code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    done_cnt = 0;
  endtask

  task automatic t_reset();
    hard_reset(2'b01);
    chk("R1 res_n", res_n, 0);
    chk("R1 warn_n", warn_n, 1);
    chk("R1 rst_done", rst_done, 0);
    chk("R1 thr_code", thr_code, 0);
  endtask

  task automatic t_powerup_long();
    rail_uv = 1'b0;
    settle();
    tk(FT + ET + DL - 1);
    chk("R4 still held before window plus long duration", res_n, 0);
    tk(1);
    chk("R5 long duration release", res_n, 1);
    chk("R10 one done pulse", done_cnt, 1);
    chk("R9 low threshold captured", thr_code, 0);
  endtask

  task automatic t_cfg_once_wd();
    cfg_code = 2'b10;
    @(negedge clk) wd_to = 1'b1;
    @(negedge clk) wd_to = 1'b0;
    chk("R7 timeout asserts reset", res_n, 0);
    tk(DL - 1);
    chk("R6 duration unchanged by new code", res_n, 0);
    tk(1);
    chk("R7 release after captured duration", res_n, 1);
    chk("R6 threshold unchanged by new code", thr_code, 0);
    chk("R10 done pulse after timeout", done_cnt, 2);
  endtask

  task automatic t_glitch();
    batt_uv = 1'b1;
    settle();
    tk(FT - 1);
    batt_uv = 1'b0;
    settle();
    tk(FT + 1);
    chk("R3 short battery glitch ignored", res_n, 1);
  endtask

  task automatic t_batt_dip();
    batt_uv = 1'b1;
    settle();
    tk(FT - 1);
    chk("R3 not yet filtered", res_n, 1);
    tk(1);
    chk("R2 battery low asserts reset", res_n, 0);
    batt_uv = 1'b0;
    settle();
    tk(FT + DL - 1);
    chk("R2 held through filter and duration", res_n, 0);
    tk(1);
    chk("R4 no second evaluation window", res_n, 1);
    chk("R10 done count after dip", done_cnt, 3);
  endtask

  task automatic t_warn();
    batt_warn = 1'b1;
    settle();
    tk(FT - 1);
    chk("R3 warning not yet filtered", warn_n, 1);
    tk(1);
    chk("R8 warning asserted", warn_n, 0);
    chk("R8 reset unaffected by warning", res_n, 1);
    batt_warn = 1'b0;
    settle();
    tk(FT);
    chk("R8 warning released", warn_n, 1);
  endtask

  task automatic t_short_high();
    hard_reset(2'b10);
    rail_uv = 1'b0;
    settle();
    tk(FT + ET + DS - 1);
    chk("R5 still held before short duration", res_n, 0);
    tk(1);
    chk("R5 short duration release", res_n, 1);
    chk("R9 high threshold captured", thr_code, 1);
    mode_3v3 = 1'b1;
    @(negedge clk);
    chk("R9 fixed threshold in 3v3 mode", thr_code, 2);
    mode_3v3 = 1'b0;
    @(negedge clk);
    chk("R9 high threshold restored", thr_code, 1);
    rail_uv = 1'b1;
    settle();
    tk(FT);
    chk("R2 rail low asserts reset", res_n, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_powerup_long();
    t_cfg_once_wd();
    t_glitch();
    t_batt_dip();
    t_warn();
    t_short_high();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule